// File: doc/BRIEF.md
# Grouped Interrupt Request Flags with Shared Vector

This block raises a CPU interrupt for a single peripheral event, here the completion of a non-volatile memory write. That source belongs to a group of sources that share one interrupt vector. Each done event sets two flags together: a per-source flag and a group flag. The group flag is what drives the shared vector.

The CPU acknowledges when it enters the vector. The acknowledge clears the group flag and the global interrupt enable, but leaves the source flag alone. Service code can then read the source flag to learn which member of the group fired, and must clear that flag itself.

A request is raised only when four conditions hold at once:
- the global enable is set;
- the source enable is set;
- the group enable is set;
- the return stack is not full.

The request output is registered.

Top module: `mf_irq_req`

## Requirements
- R1: After reset, `src_flag`, `grp_flag`, `gie` and `vec_req` are all 0.
- R2: A cycle with `done_evt` high sets both `src_flag` and `grp_flag` to 1 from the next cycle on.
- R3: `vec_req` is 1 in a cycle only if, in the previous cycle, `gie`, `src_en`, `grp_en` and `grp_flag` were all 1, `stack_full` was 0 and `vec_ack` was 0; when all of that holds, `vec_req` is 1.
- R4: A cycle with `vec_ack` high and no `done_evt` makes `grp_flag` and `gie` 0 from the next cycle on. `src_flag` is not changed by it.
- R5: `src_flag`, once set, stays 1 until a cycle with `src_flag_clr` high and `done_evt` low, after which it reads 0.
- R6: `grp_flag` goes from 0 to 1 only after a `done_evt` cycle. A `src_flag` left at 1 does not set it again.
- R7: When `done_evt` coincides with `src_flag_clr`, `grp_flag_clr` or `vec_ack`, the event wins and the affected flag reads 1 in the next cycle.
- R8: `vec_req` reads 0 in the cycle after a `vec_ack` cycle.
- R9: `gie_set` sets `gie` and `gie_clr` clears it, each from the next cycle. If `vec_ack` arrives together with `gie_set`, `gie` ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_evt | input | 1 | One-cycle memory write done event |
| src_en | input | 1 | Source interrupt enable |
| grp_en | input | 1 | Group (shared vector) interrupt enable |
| gie_set | input | 1 | Software write 1 to global enable |
| gie_clr | input | 1 | Software write 0 to global enable |
| stack_full | input | 1 | Return stack has no free entry |
| vec_ack | input | 1 | CPU is entering the shared vector |
| src_flag_clr | input | 1 | Software write 0 to source flag |
| grp_flag_clr | input | 1 | Software write 0 to group flag |
| vec_req | output | 1 | Registered shared-vector request |
| src_flag | output | 1 | Source request flag |
| grp_flag | output | 1 | Group request flag |
| gie | output | 1 | Global interrupt enable |

## Verification
The request gate is swept over all sixteen combinations of global enable, source enable, group enable and stack full, each following a fresh event. This shows that every condition alone can hold the request back.

Acknowledge sequences then separate the two flag levels. The group flag and enable must fall while the source flag survives, and the source flag must survive idle cycles without setting the group flag again.

Same-cycle collisions of the event with each clear, and of the acknowledge with a software enable set, check the precedence of each register.

// File: rtl/mf_irq_pkg.sv
package mf_irq_pkg;

    // Registered state of the request logic
    typedef struct packed {
        logic src;   // per-source request flag
        logic grp;   // group (shared vector) request flag
        logic gie;   // global interrupt enable
        logic req;   // registered vector request
    } irq_state_t;

    localparam irq_state_t IRQ_STATE_RESET = '{src: 1'b0, grp: 1'b0, gie: 1'b0, req: 1'b0};

endpackage

// File: rtl/mf_irq_src_flag.sv
module mf_irq_src_flag (
    input  logic cur_q,
    input  logic evt,
    input  logic sw_clr,
    output logic nxt_d
);
    // Event beats software clear; service entry never touches this flag
    always_comb begin
        nxt_d = cur_q;
        if (sw_clr) nxt_d = 1'b0;
        if (evt)    nxt_d = 1'b1;
    end
endmodule

// File: rtl/mf_irq_grp_flag.sv
module mf_irq_grp_flag (
    input  logic cur_q,
    input  logic evt,
    input  logic sw_clr,
    input  logic ack,
    output logic nxt_d
);
    // Set only by an event edge, never by the source flag level
    always_comb begin
        nxt_d = cur_q;
        if (sw_clr || ack) nxt_d = 1'b0;
        if (evt)           nxt_d = 1'b1;
    end
endmodule

// File: rtl/mf_irq_gie.sv
module mf_irq_gie (
    input  logic cur_q,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic ack,
    output logic nxt_d
);
    // Vector entry masks further interrupts, overriding a software set
    always_comb begin
        nxt_d = cur_q;
        if (sw_set) nxt_d = 1'b1;
        if (sw_clr) nxt_d = 1'b0;
        if (ack)    nxt_d = 1'b0;
    end
endmodule

// File: rtl/mf_irq_gate.sv
module mf_irq_gate (
    input  logic gie_q,
    input  logic src_en,
    input  logic grp_en,
    input  logic grp_q,
    input  logic stack_full,
    input  logic ack,
    output logic req_d
);
    always_comb begin
        req_d = gie_q & src_en & grp_en & grp_q & ~stack_full & ~ack;
    end
endmodule

// File: rtl/mf_irq_req.sv
module mf_irq_req
    import mf_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt,
    input  logic src_en,
    input  logic grp_en,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic stack_full,
    input  logic vec_ack,
    input  logic src_flag_clr,
    input  logic grp_flag_clr,
    output logic vec_req,
    output logic src_flag,
    output logic grp_flag,
    output logic gie
);

    irq_state_t st_q;
    irq_state_t st_d;

    logic src_nxt_d;
    logic grp_nxt_d;
    logic gie_nxt_d;
    logic req_nxt_d;

    mf_irq_src_flag u_src (
        .cur_q  (st_q.src),
        .evt    (done_evt),
        .sw_clr (src_flag_clr),
        .nxt_d  (src_nxt_d)
    );

    mf_irq_grp_flag u_grp (
        .cur_q  (st_q.grp),
        .evt    (done_evt),
        .sw_clr (grp_flag_clr),
        .ack    (vec_ack),
        .nxt_d  (grp_nxt_d)
    );

    mf_irq_gie u_gie (
        .cur_q  (st_q.gie),
        .sw_set (gie_set),
        .sw_clr (gie_clr),
        .ack    (vec_ack),
        .nxt_d  (gie_nxt_d)
    );

    mf_irq_gate u_gate (
        .gie_q      (st_q.gie),
        .src_en     (src_en),
        .grp_en     (grp_en),
        .grp_q      (st_q.grp),
        .stack_full (stack_full),
        .ack        (vec_ack),
        .req_d      (req_nxt_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.src = src_nxt_d;
        st_d.grp = grp_nxt_d;
        st_d.gie = gie_nxt_d;
        st_d.req = req_nxt_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_STATE_RESET;
        else        st_q <= st_d;
    end

    assign vec_req  = st_q.req;
    assign src_flag = st_q.src;
    assign grp_flag = st_q.grp;
    assign gie      = st_q.gie;

endmodule

// File: rtl/mf_irq_req_chk.sv
module mf_irq_req_chk (
    input logic clk,
    input logic rst_n,
    input logic done_evt,
    input logic src_en,
    input logic grp_en,
    input logic gie_set,
    input logic gie_clr,
    input logic stack_full,
    input logic vec_ack,
    input logic src_flag_clr,
    input logic grp_flag_clr,
    input logic vec_req,
    input logic src_flag,
    input logic grp_flag,
    input logic gie
);
    // R2
    evt_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (src_flag && grp_flag));

    // R3
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(gie && src_en && grp_en && grp_flag && !stack_full && !vec_ack));

    // R4
    ack_clears_grp_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !done_evt) |=> (!grp_flag && !gie));

    // R5
    src_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_flag && !src_flag_clr) |=> src_flag);

    // R6
    grp_no_level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_flag && !done_evt) |=> !grp_flag);

    // R7
    evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && (src_flag_clr || grp_flag_clr || vec_ack)) |=> (src_flag && grp_flag));

    // R8
    req_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack |=> !vec_req);

    // R9
    ack_beats_gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && gie_set) |=> !gie);

    logic unused_ok;
    assign unused_ok = gie_clr;
endmodule

bind mf_irq_req mf_irq_req_chk u_chk (.*);

// File: tb/mf_irq_req_bench.sv
module mf_irq_req_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_evt = 1'b0, src_en = 1'b0, grp_en = 1'b0;
    logic gie_set = 1'b0, gie_clr = 1'b0, stack_full = 1'b0;
    logic vec_ack = 1'b0, src_flag_clr = 1'b0, grp_flag_clr = 1'b0;
    logic vec_req, src_flag, grp_flag, gie;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mf_irq_req u_mf_irq_req (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        done_evt = 0; gie_set = 0; gie_clr = 0; vec_ack = 0;
        src_flag_clr = 0; grp_flag_clr = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        src_en = 0; grp_en = 0; stack_full = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    initial begin
        step();
        do_reset();
        step();
        chk(src_flag, 0, "R1 src_flag after reset");
        chk(grp_flag, 0, "R1 grp_flag after reset");
        chk(gie, 0, "R1 gie after reset");
        chk(vec_req, 0, "R1 vec_req after reset");

        // R3 sweep over enable / stack-full combinations
        for (int c = 0; c < 16; c++) begin
            do_reset();
            gie_set = c[0]; step(); gie_set = 0;
            src_en = c[1]; grp_en = c[2]; stack_full = c[3];
            done_evt = 1; step(); done_evt = 0;
            chk(src_flag, 1, "R2 src_flag after event");
            chk(grp_flag, 1, "R2 grp_flag after event");
            chk(vec_req, 0, "R3 request one cycle later, not yet");
            step();
            chk(vec_req, c[0] & c[1] & c[2] & ~c[3], $sformatf("R3 gate combo %0d", c));
        end

        // Acknowledge: group flag and gie drop, source flag survives
        do_reset();
        src_en = 1; grp_en = 1;
        gie_set = 1; step(); gie_set = 0;
        done_evt = 1; step(); done_evt = 0;
        step();
        chk(vec_req, 1, "R3 request raised");
        vec_ack = 1; step(); vec_ack = 0;
        chk(vec_req, 0, "R8 request drops after ack");
        chk(grp_flag, 0, "R4 grp_flag cleared by ack");
        chk(gie, 0, "R4 gie cleared by ack");
        chk(src_flag, 1, "R4 src_flag kept by ack");
        gie_set = 1; step(); gie_set = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(src_flag, 1, "R5 src_flag held while idle");
            chk(grp_flag, 0, "R6 grp_flag not re-set by src level");
            chk(vec_req, 0, "R6 no request without group flag");
        end
        src_flag_clr = 1; step(); src_flag_clr = 0;
        chk(src_flag, 0, "R5 src_flag cleared by software");

        // R3 stack full holds off, release raises one cycle later
        stack_full = 1;
        done_evt = 1; step(); done_evt = 0;
        step();
        chk(vec_req, 0, "R3 stack full blocks request");
        stack_full = 0; step();
        chk(vec_req, 1, "R3 request after stack frees");

        // R7 collisions
        src_flag_clr = 1; grp_flag_clr = 1; done_evt = 1; step(); clear_inputs();
        chk(src_flag, 1, "R7 event beats src clear");
        chk(grp_flag, 1, "R7 event beats grp clear");
        vec_ack = 1; done_evt = 1; step(); clear_inputs();
        chk(grp_flag, 1, "R7 event beats ack on grp_flag");
        chk(gie, 0, "R4 ack clears gie even with event");
        chk(vec_req, 0, "R8 request low after ack");
        grp_flag_clr = 1; step(); clear_inputs();
        chk(grp_flag, 0, "R6 software clear of grp_flag");

        // R9 global enable writes
        gie_set = 1; vec_ack = 1; step(); clear_inputs();
        chk(gie, 0, "R9 ack beats gie set");
        gie_set = 1; step(); clear_inputs();
        chk(gie, 1, "R9 gie set");
        gie_clr = 1; step(); clear_inputs();
        chk(gie, 0, "R9 gie clear");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule